// File: doc/BRIEF.md
# Memory Mailbox Ring Pointer Manager

This block keeps the pointer bookkeeping for a set of ring buffers ("mailboxes") that live in system memory. The device deposits fixed-size indication entries into them and a host processor drains them. For every mailbox the block holds four address registers: a ring start, an exclusive ring end, a write pointer owned by the device, and a tail (read) pointer owned by the host. It does not move any data. On each indication it presents the target address, then advances the write pointer and wraps it to the start at the ring end.

A per-mailbox "posted" status bit records each accepted indication. A "full" bit records the moment when the advanced write pointer lands on the host's tail. Any status bit whose mask bit is clear drives the interrupt. While any mailbox sits in the full state, a stall output tells the command engine to stop. The host clears that state by moving the tail pointer away from the write pointer, or by reprogramming the ring start.

Top module: `mbx_ring_mgr`

## Requirements
- R1: After reset every address register, the status register and the mask register read 0, and `irq` and `stall` are low.
- R2: Writing a mailbox's start register (register index mailbox*4+0) loads the start, write pointer and tail of that mailbox with the written value, with bits [1:0] forced to 0. It also leaves that mailbox not full.
- R3: `ind_addr` shows the current write pointer of the mailbox selected by `ind_mbox`. An accepted indication advances that write pointer by ENTRY_BYTES (16 by default) on the next clock.
- R4: When the advanced write pointer equals the mailbox's end register (index mailbox*4+1, exclusive), the start address is loaded into the write pointer instead.
- R5: Each accepted indication sets status bit m (the posted bit) for mailbox m.
- R6: When the write pointer after an advance equals the tail, the mailbox enters the full state and status bit NUM_MBOX+m is set. `stall` is high while any mailbox is in the full state.
- R7: An indication to a mailbox in the full state is ignored: its write pointer does not move and its posted bit is not set.
- R8: The tail register (index mailbox*4+3) is written only by the host. Writing it with a value different from the write pointer releases the full state. The write-pointer register (index mailbox*4+2) is read-only, and a write to it is ignored.
- R9: The status register (index NUM_MBOX*4) is write-1-to-clear. A status bit that is set by an event in the same cycle as it is cleared stays set.
- R10: The mask register (index NUM_MBOX*4+1) has the same bit layout as the status register. `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R11: `reg_rdata` returns the register selected by `reg_addr` in the same cycle. Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (5) | Register index for reads and writes |
| reg_wdata | input | AW (32) | Register write data |
| reg_rdata | output | AW (32) | Register read data, combinational |
| ind_valid | input | 1 | An indication is being written this cycle |
| ind_mbox | input | MBW (2) | Mailbox the indication goes to |
| ind_addr | output | AW (32) | Target address for the indication in the selected mailbox |
| irq | output | 1 | Interrupt: any unmasked status bit |
| stall | output | 1 | High while any mailbox is full |

## Verification
The ring walk is driven three ways. One ring has a misaligned tail, so it wraps at its end without ever filling. A second ring wraps straight onto its tail and fills. A third has its tail moved one entry ahead, so it fills in the middle of the ring. These runs separate wrap logic from full detection. Further patterns target the ignored cases: indications sent to a full ring, writes to the read-only write pointer, and unmapped register reads. They also cover the collision of a write-1-to-clear with a same-cycle posted event, and the release of the full state through either a tail write or a start write. Mask and status combinations then show that the interrupt follows only unmasked bits, independently of the stall.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Per-mailbox register slot, taken from the low two bits of the register index.
    typedef enum logic [1:0] {
        FLD_START  = 2'd0,
        FLD_END    = 2'd1,
        FLD_WPTR   = 2'd2,
        FLD_TAIL   = 2'd3
    } mbx_field_e;

    localparam int REGS_PER_MBOX = 4;

endpackage

// File: rtl/mbx_ring_slot.sv
module mbx_ring_slot
    import mbx_pkg::*;
#(
    parameter int AW          = 32,
    parameter int ENTRY_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  mbx_field_e       cfg_field,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             ind_req,
    output logic [AW-1:0]    start_o,
    output logic [AW-1:0]    end_o,
    output logic [AW-1:0]    wptr_o,
    output logic [AW-1:0]    tail_o,
    output logic             full_o,
    output logic             posted_o,
    output logic             filled_o
);

    localparam logic [AW-1:0] STEP = AW'(ENTRY_BYTES);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] ring_end;
        logic [AW-1:0] wptr;
        logic [AW-1:0] tail;
        logic          full;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  posted_d, filled_d;
    logic [AW-1:0] adv;
    logic [AW-1:0] nxt;
    logic [AW-1:0] aligned;

    always_comb begin
        slot_d   = slot_q;
        posted_d = 1'b0;
        filled_d = 1'b0;
        adv      = slot_q.wptr + STEP;
        nxt      = (adv == slot_q.ring_end) ? slot_q.start : adv;
        aligned  = {cfg_wdata[AW-1:2], 2'b00};

        // Device side: accept only while the ring has room.
        if (ind_req && !slot_q.full) begin
            posted_d    = 1'b1;
            slot_d.wptr = nxt;
            if (nxt == slot_q.tail) begin
                slot_d.full = 1'b1;
                filled_d    = 1'b1;
            end
        end

        // Host side: applied on top of the device update.
        if (cfg_we) begin
            unique case (cfg_field)
                FLD_START: begin
                    slot_d.start = aligned;
                    slot_d.wptr  = aligned;
                    slot_d.tail  = aligned;
                    slot_d.full  = 1'b0;
                end
                FLD_END: slot_d.ring_end = aligned;
                FLD_TAIL: begin
                    slot_d.tail = aligned;
                    if (aligned != slot_d.wptr) begin
                        slot_d.full = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign start_o  = slot_q.start;
    assign end_o    = slot_q.ring_end;
    assign wptr_o   = slot_q.wptr;
    assign tail_o   = slot_q.tail;
    assign full_o   = slot_q.full;
    assign posted_o = posted_d;
    assign filled_o = filled_d;

endmodule

// File: rtl/mbx_irq_status.sv
module mbx_irq_status #(
    parameter int NUM_MBOX = 4,
    localparam int SW      = 2 * NUM_MBOX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MBOX-1:0] posted_set,
    input  logic [NUM_MBOX-1:0] full_set,
    input  logic                clr_we,
    input  logic                mask_we,
    input  logic [SW-1:0]       wdata,
    output logic [SW-1:0]       status_o,
    output logic [SW-1:0]       mask_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [SW-1:0] status;
        logic [SW-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.status = st_d.status & ~wdata;
        end
        // New events win over a clear in the same cycle.
        st_d.status = st_d.status | {full_set, posted_set};
        if (mask_we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);

endmodule

// File: rtl/mbx_ring_mgr.sv
module mbx_ring_mgr
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX    = 4,
    parameter int AW          = 32,
    parameter int ENTRY_BYTES = 16,
    parameter int REG_AW      = 5,
    localparam int MBW        = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              ind_valid,
    input  logic [MBW-1:0]    ind_mbox,
    output logic [AW-1:0]     ind_addr,
    output logic              irq,
    output logic              stall
);

    localparam int SW = 2 * NUM_MBOX;
    localparam int IW = REG_AW - 2;
    localparam logic [REG_AW-1:0] ADDR_STATUS = REG_AW'(NUM_MBOX * REGS_PER_MBOX);
    localparam logic [REG_AW-1:0] ADDR_MASK   = REG_AW'(NUM_MBOX * REGS_PER_MBOX + 1);

    logic [AW-1:0]       start_a [NUM_MBOX];
    logic [AW-1:0]       end_a   [NUM_MBOX];
    logic [AW-1:0]       wptr_a  [NUM_MBOX];
    logic [AW-1:0]       tail_a  [NUM_MBOX];
    logic [NUM_MBOX-1:0] full_a;
    logic [NUM_MBOX-1:0] posted_v;
    logic [NUM_MBOX-1:0] filled_v;
    logic [SW-1:0]       status_v;
    logic [SW-1:0]       mask_v;

    logic       in_ring_space;
    mbx_field_e sel_field;

    assign in_ring_space = (reg_addr < ADDR_STATUS);
    assign sel_field     = mbx_field_e'(reg_addr[1:0]);

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
        logic slot_we;
        logic slot_ind;
        assign slot_we  = reg_we && in_ring_space && (reg_addr[REG_AW-1:2] == IW'(m));
        assign slot_ind = ind_valid && (ind_mbox == MBW'(m));

        mbx_ring_slot #(
            .AW          (AW),
            .ENTRY_BYTES (ENTRY_BYTES)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (slot_we),
            .cfg_field (sel_field),
            .cfg_wdata (reg_wdata),
            .ind_req   (slot_ind),
            .start_o   (start_a[m]),
            .end_o     (end_a[m]),
            .wptr_o    (wptr_a[m]),
            .tail_o    (tail_a[m]),
            .full_o    (full_a[m]),
            .posted_o  (posted_v[m]),
            .filled_o  (filled_v[m])
        );
    end

    mbx_irq_status #(
        .NUM_MBOX (NUM_MBOX)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .posted_set (posted_v),
        .full_set   (filled_v),
        .clr_we     (reg_we && (reg_addr == ADDR_STATUS)),
        .mask_we    (reg_we && (reg_addr == ADDR_MASK)),
        .wdata      (reg_wdata[SW-1:0]),
        .status_o   (status_v),
        .mask_o     (mask_v),
        .irq_o      (irq)
    );

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS) begin
            reg_rdata = AW'(status_v);
        end else if (reg_addr == ADDR_MASK) begin
            reg_rdata = AW'(mask_v);
        end else if (in_ring_space) begin
            for (int m = 0; m < NUM_MBOX; m++) begin
                if (reg_addr[REG_AW-1:2] == IW'(m)) begin
                    unique case (sel_field)
                        FLD_START: reg_rdata = start_a[m];
                        FLD_END:   reg_rdata = end_a[m];
                        FLD_WPTR:  reg_rdata = wptr_a[m];
                        FLD_TAIL:  reg_rdata = tail_a[m];
                        default:   reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // Target address of the selected mailbox.
    always_comb begin
        ind_addr = '0;
        for (int m = 0; m < NUM_MBOX; m++) begin
            if (ind_mbox == MBW'(m)) begin
                ind_addr = wptr_a[m];
            end
        end
    end

    assign stall = |full_a;

endmodule

// File: rtl/mbx_ring_mgr_chk.sv
module mbx_ring_mgr_chk #(
    parameter int NUM_MBOX    = 4,
    parameter int AW          = 32,
    parameter int ENTRY_BYTES = 16,
    parameter int MBW         = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic                  ind_valid,
    input logic [MBW-1:0]        ind_mbox,
    input logic                  irq,
    input logic                  stall,
    input logic [AW-1:0]         start_a [NUM_MBOX],
    input logic [AW-1:0]         end_a   [NUM_MBOX],
    input logic [AW-1:0]         wptr_a  [NUM_MBOX],
    input logic [NUM_MBOX-1:0]   full_a,
    input logic [2*NUM_MBOX-1:0] status_v
);

    localparam logic [AW-1:0] STEP = AW'(ENTRY_BYTES);

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
        logic hit;
        assign hit = ind_valid && (ind_mbox == MBW'(m));

        assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !full_a[m] && !reg_we && (wptr_a[m] + STEP != end_a[m]))
            |=> (wptr_a[m] == $past(wptr_a[m]) + STEP));

        assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !full_a[m] && !reg_we && (wptr_a[m] + STEP == end_a[m]))
            |=> (wptr_a[m] == $past(start_a[m])));

        assert_posted_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !full_a[m]) |=> status_v[m]);

        assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && full_a[m] && !reg_we) |=> $stable(wptr_a[m]));
    end

    // R6: only a host write can release a stall.
    assert_stall_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !reg_we) |=> stall);

    // R10: no interrupt without a pending status bit.
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_v == '0) |-> !irq);

endmodule

bind mbx_ring_mgr mbx_ring_mgr_chk #(
    .NUM_MBOX    (NUM_MBOX),
    .AW          (AW),
    .ENTRY_BYTES (ENTRY_BYTES),
    .MBW         (MBW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .ind_valid (ind_valid),
    .ind_mbox  (ind_mbox),
    .irq       (irq),
    .stall     (stall),
    .start_a   (start_a),
    .end_a     (end_a),
    .wptr_a    (wptr_a),
    .full_a    (full_a),
    .status_v  (status_v)
);

// File: tb/tb_mbx_ring_mgr.sv
module tb_mbx_ring_mgr;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_I = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;
    localparam int NVEC = 41;

    // {op, index, data (write value or expected read), expected irq, expected stall}
    localparam logic [40:0] VEC [NVEC] = '{
        {OP_W, 5'd0,  32'h40,  1'b0, 1'b0},  // R2 mb0 start
        {OP_W, 5'd1,  32'h60,  1'b0, 1'b0},  // mb0 end
        {OP_W, 5'd3,  32'h48,  1'b0, 1'b0},  // R8 tail off-grid
        {OP_R, 5'd0,  32'h40,  1'b0, 1'b0},  // R11
        {OP_R, 5'd2,  32'h40,  1'b0, 1'b0},  // R2 wptr follows start
        {OP_I, 5'd0,  32'h0,   1'b1, 1'b0},  // R5 posted -> irq
        {OP_R, 5'd2,  32'h50,  1'b1, 1'b0},  // R3 advance
        {OP_I, 5'd0,  32'h0,   1'b1, 1'b0},  // R4 reaches end
        {OP_R, 5'd2,  32'h40,  1'b1, 1'b0},  // R4 wrapped, no full
        {OP_R, 5'd16, 32'h1,   1'b1, 1'b0},  // R5 status
        {OP_W, 5'd16, 32'h1,   1'b0, 1'b0},  // R9 clear
        {OP_R, 5'd16, 32'h0,   1'b0, 1'b0},  // R9
        {OP_W, 5'd4,  32'h100, 1'b0, 1'b0},  // mb1 start
        {OP_W, 5'd5,  32'h140, 1'b0, 1'b0},  // mb1 end
        {OP_R, 5'd7,  32'h100, 1'b0, 1'b0},  // R2 tail follows start
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b0},
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b0},
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b0},
        {OP_R, 5'd6,  32'h130, 1'b1, 1'b0},  // R3
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b1},  // R6 wrap onto tail -> full
        {OP_R, 5'd6,  32'h100, 1'b1, 1'b1},  // R4
        {OP_R, 5'd16, 32'h22,  1'b1, 1'b1},  // R6 full bit 5
        {OP_W, 5'd16, 32'h2,   1'b1, 1'b1},  // R9
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b1},  // R7 ignored
        {OP_R, 5'd16, 32'h20,  1'b1, 1'b1},  // R7 no posted
        {OP_R, 5'd6,  32'h100, 1'b1, 1'b1},  // R7 no move
        {OP_W, 5'd7,  32'h110, 1'b1, 1'b0},  // R8 release
        {OP_W, 5'd16, 32'h20,  1'b0, 1'b0},  // R9
        {OP_I, 5'd1,  32'h0,   1'b1, 1'b1},  // R6 mid-ring full
        {OP_W, 5'd6,  32'h999, 1'b1, 1'b1},  // R8 wptr read-only
        {OP_R, 5'd6,  32'h110, 1'b1, 1'b1},  // R8
        {OP_W, 5'd17, 32'h22,  1'b0, 1'b1},  // R10 mask both
        {OP_R, 5'd17, 32'h22,  1'b0, 1'b1},  // R11
        {OP_W, 5'd7,  32'h130, 1'b0, 1'b0},  // R8 release
        {OP_W, 5'd17, 32'h0,   1'b1, 1'b0},  // R10 unmask
        {OP_W, 5'd16, 32'hFF,  1'b0, 1'b0},  // R9
        {OP_R, 5'd16, 32'h0,   1'b0, 1'b0},
        {OP_W, 5'd8,  32'h203, 1'b0, 1'b0},  // R2 alignment
        {OP_R, 5'd10, 32'h200, 1'b0, 1'b0},  // R2
        {OP_R, 5'd11, 32'h200, 1'b0, 1'b0},  // R2
        {OP_R, 5'd18, 32'h0,   1'b0, 1'b0}   // R11 unused index
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ind_valid = 1'b0;
    logic [1:0]  ind_mbox = '0;
    logic [31:0] ind_addr;
    logic        irq;
    logic        stall;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbx_ring_mgr dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ind_valid (ind_valid),
        .ind_mbox  (ind_mbox),
        .ind_addr  (ind_addr),
        .irq       (irq),
        .stall     (stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        if (op == OP_W) begin
            reg_we    = 1'b1;
            reg_wdata = d;
        end else if (op == OP_I) begin
            ind_valid = 1'b1;
            ind_mbox  = a[1:0];
        end
        if (op != OP_R) begin
            @(negedge clk);
            reg_we    = 1'b0;
            ind_valid = 1'b0;
        end
        #1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        reg_addr = 5'd16;
        #1;
        chk("R1 status", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 stall", {31'b0, stall}, 32'h0);
        rst_n = 1'b1;
        reg_addr = 5'd14;
        #1;
        chk("R1 mb3 wptr", reg_rdata, 32'h0);
        reg_addr = 5'd17;
        #1;
        chk("R1 mask", reg_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [4:0]  a;
            logic [31:0] d;
            logic        e_irq;
            logic        e_stall;
            {op, a, d, e_irq, e_stall} = VEC[i];
            run_op(op, a, d);
            if (op == OP_R) begin
                chk($sformatf("R11 table step %0d rdata", i), reg_rdata, d);
            end
            chk($sformatf("R10 table step %0d irq", i), {31'b0, irq}, {31'b0, e_irq});
            chk($sformatf("R6 table step %0d stall", i), {31'b0, stall}, {31'b0, e_stall});
        end

        // R3: target address is the selected write pointer
        ind_mbox = 2'd1;
        #1;
        chk("R3 ind_addr mb1", ind_addr, 32'h110);
        ind_mbox = 2'd2;
        #1;
        chk("R3 ind_addr mb2", ind_addr, 32'h200);

        // R9: a posted event beats a same-cycle clear of its bit
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 5'd16;
        reg_wdata = 32'h4;
        ind_valid = 1'b1;
        ind_mbox  = 2'd2;
        @(negedge clk);
        reg_we    = 1'b0;
        ind_valid = 1'b0;
        #1;
        chk("R9 set wins over clear", reg_rdata, 32'h4);
        chk("R5 irq after posted", {31'b0, irq}, 32'h1);
        reg_addr = 5'd10;
        #1;
        chk("R3 mb2 advanced", reg_rdata, 32'h210);

        // R2: a start write releases the full state
        run_op(OP_W, 5'd12, 32'h300);
        run_op(OP_W, 5'd13, 32'h310);
        run_op(OP_I, 5'd3, 32'h0);
        chk("R6 mb3 full stall", {31'b0, stall}, 32'h1);
        reg_addr = 5'd16;
        #1;
        chk("R6 mb3 status", reg_rdata, 32'h8C);
        run_op(OP_W, 5'd12, 32'h300);
        chk("R2 start releases stall", {31'b0, stall}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule